// File: doc/BRIEF.md
# Nine-bit command/parameter SPI serializer

This block is a write-only, three-wire serial master that feeds a display controller. An upstream agent hands it one sequence at a time. It first gives a start strobe, which also says whether the sequence is empty. It then streams bytes over a valid/ready handshake and marks the final byte with a last flag. Every byte leaves the block as a 9-bit word, most significant bit first, in SPI mode 0. Chip select is held low for the length of each word. Bit 8 of the word tells the receiver what the byte is: clear for the opening byte of a sequence (a command) and set for every byte after it (a parameter).

Each sequence that reaches the bus is followed by a mandatory quiet period, and this includes a sequence that failed. No new sequence is accepted until that period has run out. Its length is a parameter given in microseconds and converted to clock cycles. A transfer-fault input reports a failing word. The block still finishes that word, but it sends none of the remaining bytes: it accepts and discards them. It then raises a sticky error flag. While the flag is up, every new sequence is consumed and dropped without touching the bus. A clear strobe captures the flag's current value into a snapshot output and drops the flag.

Top module: `cdspi_tx`

## Requirements
- R1: Every word is 9 bits, shifted out MSB first. Chip select is low for exactly one word at a time. SCLK rests low while chip select is high, and MOSI only changes while SCLK is low (mode 0).
- R2: The first byte of a sequence goes out as word {1'b0, byte}, meaning bit 8 = 0 (command).
- R3: Every later byte of the same sequence goes out as word {1'b1, byte}, meaning bit 8 = 1 (parameter).
- R4: A start with seq_empty = 1 produces no bus activity and starts no quiet period. seq_ready is high again in the cycle after the start.
- R5: While err_flag is 1, a started sequence is skipped. All of its bytes are accepted and discarded, no word reaches the bus, and err_flag stays 1.
- R6: A fault_in pulse while a word is on the bus lets that word finish. The remaining bytes of the sequence are accepted but never sent, and err_flag becomes 1.
- R7: After the last word of a sent sequence (normal or failed), seq_ready stays low and no command word starts earlier than GAP_US microseconds, counted in clock cycles from the chip-select rise of that last word.
- R8: An err_clr pulse loads err_snap with the value err_flag held before the pulse and returns err_flag to 0.
- R9: After reset, spi_csn = 1, spi_sclk = 0, err_flag = 0, byte_ready = 0 and seq_ready = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| seq_start | input | 1 | One-cycle strobe that opens a sequence, taken only while seq_ready is high |
| seq_empty | input | 1 | Qualifies seq_start: the sequence has no bytes |
| seq_ready | output | 1 | Block is idle and the quiet period has elapsed |
| byte_valid | input | 1 | byte_data holds a byte of the open sequence |
| byte_data | input | 8 | Byte to send |
| byte_last | input | 1 | The offered byte is the final one of the sequence |
| byte_ready | output | 1 | Byte is taken on a clock edge where byte_valid and byte_ready are both high |
| fault_in | input | 1 | Transfer fault for the word currently on the bus |
| err_clr | input | 1 | Strobe: snapshot and clear the sticky error |
| err_flag | output | 1 | Sticky error |
| err_snap | output | 1 | Value of err_flag captured by the last err_clr |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_csn | output | 1 | Chip select, active low, one word per assertion |
| spi_mosi | output | 1 | Serial data out |

## Verification
Suppose the controller lost track of its position inside a sequence. The very next word would carry the wrong bit 8, and the bus decoder would report it when chip select rises. A shifter that slipped a half period would show up in the same cycle as a short word or as MOSI moving while SCLK is high. A quiet-period counter that was too short, or an error flag that was lost, does not appear until the next sequence. It then shows as a command word starting too early, or as words that should have been dropped appearing on the bus. For that reason every scenario is followed by another sequence.

// File: rtl/cdspi_pkg.sv
// Shared types for the nine-bit serializer.
// Assumes: one byte maps to one 9-bit word; bit 8 is the command/parameter flag.
package cdspi_pkg;

    localparam int WORD_W = 9;
    localparam int BYTE_W = 8;

    typedef logic [WORD_W-1:0] spi_word_t;

    typedef enum logic [1:0] {
        ST_IDLE,   // waiting for a start
        ST_FETCH,  // waiting for the next byte
        ST_SEND,   // a word is on the bus
        ST_DRAIN   // swallowing bytes that must not be sent
    } seq_st_t;

    // Builds a bus word; is_param = 1 marks a parameter byte.
    function automatic spi_word_t mk_word(input logic is_param, input logic [BYTE_W-1:0] b);
        return {is_param, b};
    endfunction

endpackage

// File: rtl/cdspi_shift.sv
// Word shifter: sends one 9-bit word MSB first in SPI mode 0.
// A word takes 2*WORD_W half periods with chip select low, then one more
// half period with chip select high (guard) before done pulses.
// Assumes: go is only raised while busy is low; HALF_CYC >= 1.
module cdspi_shift
    import cdspi_pkg::*;
#(
    parameter int HALF_CYC = 5
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      go,
    input  spi_word_t word,
    output logic      busy,
    output logic      done,
    output logic      sclk,
    output logic      csn,
    output logic      mosi
);
    localparam int HALVES = 2 * WORD_W;
    localparam int PH_W   = $clog2(HALVES + 1);
    localparam int DIV_W  = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    logic             active_q;
    logic             csn_q;
    logic             sclk_q;
    logic             done_q;
    spi_word_t        sreg_q;
    logic [DIV_W-1:0] div_q;
    logic [PH_W-1:0]  ph_q;

    // Half-period sequencing of chip select, clock and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            csn_q    <= 1'b1;
            sclk_q   <= 1'b0;
            done_q   <= 1'b0;
            sreg_q   <= '0;
            div_q    <= '0;
            ph_q     <= '0;
        end else begin
            done_q <= 1'b0;
            if (!active_q) begin
                if (go) begin
                    active_q <= 1'b1;
                    csn_q    <= 1'b0;
                    sreg_q   <= word;
                    div_q    <= '0;
                    ph_q     <= '0;
                end
            end else if (div_q == DIV_W'(HALF_CYC - 1)) begin
                div_q <= '0;
                ph_q  <= ph_q + 1'b1;
                if (ph_q == PH_W'(HALVES - 1)) begin
                    csn_q  <= 1'b1;
                    sclk_q <= 1'b0;
                end else if (ph_q == PH_W'(HALVES)) begin
                    active_q <= 1'b0;
                    done_q   <= 1'b1;
                end else if (!ph_q[0]) begin
                    sclk_q <= 1'b1;
                end else begin
                    sclk_q <= 1'b0;
                    sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
                end
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    assign busy = active_q;
    assign done = done_q;
    assign sclk = sclk_q;
    assign csn  = csn_q;
    assign mosi = sreg_q[WORD_W-1];

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        csn_q |-> !sclk_q); // R1
    AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_q && $past(sclk_q)) |-> $stable(sreg_q[WORD_W-1])); // R1
    AST_GO_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !active_q); // R1

endmodule

// File: rtl/cdspi_gap.sv
// Quiet-period timer: after go, busy stays high for GAP_CYC cycles.
// Assumes: GAP_CYC >= 1.
module cdspi_gap #(
    parameter int GAP_CYC = 30000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic busy
);
    localparam int CW = $clog2(GAP_CYC + 1);

    logic [CW-1:0] cnt_q;

    // Load on go, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (go)           cnt_q <= CW'(GAP_CYC);
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

    AST_GAP_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> busy); // R7

endmodule

// File: rtl/cdspi_seq.sv
// Sequence controller: takes a start and a byte stream, tags the first byte
// as command and the rest as parameters, hands words to the shifter, arms
// the quiet period, and keeps the sticky error.
// Assumes: seq_start is honoured only with seq_ready high; fault_in is
// meaningful only while a word is on the bus.
module cdspi_seq
    import cdspi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seq_start,
    input  logic              seq_empty,
    output logic              seq_ready,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              byte_last,
    output logic              byte_ready,
    input  logic              fault_in,
    input  logic              err_clr,
    output logic              err_flag,
    output logic              err_snap,
    output logic              tx_go,
    output spi_word_t         tx_word,
    input  logic              tx_busy,
    input  logic              tx_done,
    output logic              gap_go,
    input  logic              gap_busy
);
    seq_st_t st_q;
    logic    first_q;
    logic    last_q;
    logic    fault_seen_q;
    logic    err_q;
    logic    snap_q;
    logic    word_fault;
    logic    word_end;

    // Handshake and hand-off decode.
    always_comb begin
        seq_ready  = (st_q == ST_IDLE) && !gap_busy;
        byte_ready = ((st_q == ST_FETCH) && !tx_busy) || (st_q == ST_DRAIN);
        tx_go      = (st_q == ST_FETCH) && !tx_busy && byte_valid;
        tx_word    = mk_word(!first_q, byte_data);
        word_fault = fault_seen_q || fault_in;
        word_end   = (st_q == ST_SEND) && tx_done;
        gap_go     = word_end && (last_q || word_fault);
    end

    // Sequence state walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= ST_IDLE;
            first_q      <= 1'b0;
            last_q       <= 1'b0;
            fault_seen_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (seq_start && seq_ready && !seq_empty) begin
                        if (err_q) begin
                            st_q <= ST_DRAIN;
                        end else begin
                            st_q    <= ST_FETCH;
                            first_q <= 1'b1;
                        end
                    end
                end
                ST_FETCH: begin
                    if (tx_go) begin
                        st_q         <= ST_SEND;
                        first_q      <= 1'b0;
                        last_q       <= byte_last;
                        fault_seen_q <= 1'b0;
                    end
                end
                ST_SEND: begin
                    if (fault_in) fault_seen_q <= 1'b1;
                    if (tx_done) begin
                        if (last_q)          st_q <= ST_IDLE;
                        else if (word_fault) st_q <= ST_DRAIN;
                        else                 st_q <= ST_FETCH;
                    end
                end
                ST_DRAIN: begin
                    if (byte_valid && byte_last) st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Sticky error and the snapshot taken on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q  <= 1'b0;
            snap_q <= 1'b0;
        end else begin
            if (err_clr) snap_q <= err_q;
            if (word_end && word_fault) err_q <= 1'b1;
            else if (err_clr)           err_q <= 1'b0;
        end
    end

    assign err_flag = err_q;
    assign err_snap = snap_q;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !err_clr) |=> err_q); // R5
    AST_NO_WORD_WHEN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> !tx_go); // R5
    AST_NO_WORD_IN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        gap_busy |-> !tx_go); // R7
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !(word_end && word_fault)) |=> !err_q); // R8

endmodule

// File: rtl/cdspi_tx.sv
// Top of the nine-bit command/parameter serializer. Derives the SCLK half
// period and the quiet period from the system clock and wires controller,
// shifter and timer together.
// Assumes: CLK_HZ >= 2*SCLK_HZ for the intended rate (minimum half period
// is one clock); CLK_HZ is a multiple of 1 MHz.
module cdspi_tx
    import cdspi_pkg::*;
#(
    parameter int CLK_HZ  = 100_000_000,
    parameter int SCLK_HZ = 10_000_000,
    parameter int GAP_US  = 300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seq_start,
    input  logic              seq_empty,
    output logic              seq_ready,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              byte_last,
    output logic              byte_ready,
    input  logic              fault_in,
    input  logic              err_clr,
    output logic              err_flag,
    output logic              err_snap,
    output logic              spi_sclk,
    output logic              spi_csn,
    output logic              spi_mosi
);
    localparam int HALF_RAW = CLK_HZ / (2 * SCLK_HZ);
    localparam int HALF_CYC = (HALF_RAW < 1) ? 1 : HALF_RAW;
    localparam int GAP_RAW  = (CLK_HZ / 1_000_000) * GAP_US;
    localparam int GAP_CYC  = (GAP_RAW < 1) ? 1 : GAP_RAW;

    logic      tx_go;
    spi_word_t tx_word;
    logic      tx_busy;
    logic      tx_done;
    logic      gap_go;
    logic      gap_busy;

    cdspi_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .seq_start  (seq_start),
        .seq_empty  (seq_empty),
        .seq_ready  (seq_ready),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .byte_last  (byte_last),
        .byte_ready (byte_ready),
        .fault_in   (fault_in),
        .err_clr    (err_clr),
        .err_flag   (err_flag),
        .err_snap   (err_snap),
        .tx_go      (tx_go),
        .tx_word    (tx_word),
        .tx_busy    (tx_busy),
        .tx_done    (tx_done),
        .gap_go     (gap_go),
        .gap_busy   (gap_busy)
    );

    cdspi_shift #(.HALF_CYC(HALF_CYC)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (tx_go),
        .word  (tx_word),
        .busy  (tx_busy),
        .done  (tx_done),
        .sclk  (spi_sclk),
        .csn   (spi_csn),
        .mosi  (spi_mosi)
    );

    cdspi_gap #(.GAP_CYC(GAP_CYC)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (gap_go),
        .busy  (gap_busy)
    );

endmodule

// File: tb/cdspi_tx_tb_top.sv
// Bench: behavioural bus decoder plus expected-word queue, checked each clock.
module cdspi_tx_tb_top;
    localparam int GAP_US  = 20;
    localparam int GAP_CYC = 100 * GAP_US;   // 100 MHz clock

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       seq_start = 1'b0;
    logic       seq_empty = 1'b0;
    logic       seq_ready;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = '0;
    logic       byte_last = 1'b0;
    logic       byte_ready;
    logic       fault_in = 1'b0;
    logic       err_clr = 1'b0;
    logic       err_flag;
    logic       err_snap;
    logic       spi_sclk;
    logic       spi_csn;
    logic       spi_mosi;

    cdspi_tx #(.CLK_HZ(100_000_000), .SCLK_HZ(10_000_000), .GAP_US(GAP_US)) dut_i (
        .clk(clk), .rst_n(rst_n), .seq_start(seq_start), .seq_empty(seq_empty),
        .seq_ready(seq_ready), .byte_valid(byte_valid), .byte_data(byte_data),
        .byte_last(byte_last), .byte_ready(byte_ready), .fault_in(fault_in),
        .err_clr(err_clr), .err_flag(err_flag), .err_snap(err_snap),
        .spi_sclk(spi_sclk), .spi_csn(spi_csn), .spi_mosi(spi_mosi)
    );

    always #5 clk = ~clk;

    int         vectors = 0;
    int         fails = 0;
    int         cyc = 0;
    int         last_rise = -1000000;
    int         words_seen = 0;
    int         exp_total = 0;
    int         fault_word = -1;
    int         bitcnt = 0;
    logic [8:0] cur = '0;
    logic       prev_csn = 1'b1;
    logic       prev_sclk = 1'b0;
    logic       prev_mosi = 1'b0;
    logic       model_err = 1'b0;
    logic [8:0] exp_q[$];
    logic [7:0] q[$];
    bit         done_flag = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Bus decoder, bus-rule checks and fault injection, every clock.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk(!(spi_csn && spi_sclk), "R1 sclk low while deselected", spi_sclk, 0);
            if (!spi_csn && spi_sclk && prev_sclk)
                chk(spi_mosi == prev_mosi, "R1 mosi stable while sclk high", spi_mosi, prev_mosi);
            if (!spi_csn && prev_csn) begin
                bitcnt = 0;
                cur = '0;
            end
            if (!spi_csn && spi_sclk && !prev_sclk) begin
                if (bitcnt == 0 && spi_mosi == 1'b0)
                    chk(cyc - last_rise >= GAP_CYC, "R7 quiet period", cyc - last_rise, GAP_CYC);
                cur = {cur[7:0], spi_mosi};
                bitcnt++;
            end
            if (spi_csn && !prev_csn) begin
                last_rise = cyc;
                chk(bitcnt == 9, "R1 word length", bitcnt, 9);
                if (exp_q.size() == 0) begin
                    chk(0, "R5 R6 unexpected word", int'(cur), 0);
                end else begin
                    logic [8:0] e;
                    e = exp_q.pop_front();
                    chk(cur == e, e[8] ? "R3 parameter word" : "R2 command word", int'(cur), int'(e));
                end
                words_seen++;
            end
        end
        prev_csn  = spi_csn;
        prev_sclk = spi_sclk;
        prev_mosi = spi_mosi;
        if (fault_in) fault_in = 1'b0;
        else if (fault_word >= 0 && !spi_csn && words_seen == fault_word) begin
            fault_in = 1'b1;
            fault_word = -1;
        end
    end

    // One sequence; fault_k >= 0 injects a fault on that byte's word.
    task automatic run_seq(input int fault_k);
        int n;
        n = q.size();
        @(negedge clk);
        while (!seq_ready) @(negedge clk);
        if (!model_err && n > 0) begin
            for (int i = 0; i < n; i++) begin
                if (fault_k >= 0 && i > fault_k) break;
                exp_q.push_back({(i != 0), q[i]});
            end
            if (fault_k >= 0) begin
                fault_word = exp_total + fault_k;
                exp_total = exp_total + fault_k + 1;
                model_err = 1'b1;
            end else begin
                exp_total = exp_total + n;
            end
        end
        seq_start = 1'b1;
        seq_empty = (n == 0);
        @(negedge clk);
        seq_start = 1'b0;
        seq_empty = 1'b0;
        for (int i = 0; i < n; i++) begin
            byte_valid = 1'b1;
            byte_data  = q[i];
            byte_last  = (i == n - 1);
            forever begin
                if (byte_ready) begin
                    @(negedge clk);
                    break;
                end
                @(negedge clk);
            end
        end
        byte_valid = 1'b0;
        byte_last  = 1'b0;
    endtask

    task automatic wait_bus_quiet();
        while (exp_q.size() != 0 || !spi_csn) @(negedge clk);
        repeat (15) @(negedge clk);
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(spi_csn == 1'b1, "R9 csn after reset", spi_csn, 1);
        chk(spi_sclk == 1'b0, "R9 sclk after reset", spi_sclk, 0);
        chk(err_flag == 1'b0, "R9 err after reset", err_flag, 0);
        chk(byte_ready == 1'b0, "R9 byte_ready after reset", byte_ready, 0);
        chk(seq_ready == 1'b1, "R9 seq_ready after reset", seq_ready, 1);

        // R2 single command
        q = '{8'h11};
        run_seq(-1);
        wait_bus_quiet();
        chk(seq_ready == 1'b0, "R7 seq_ready low after sequence", seq_ready, 0);

        // R2 R3 short sequence
        q = '{8'hF0, 8'h5A, 8'h5A};
        run_seq(-1);

        // R3 long sequence with computed bytes
        q.delete();
        for (int i = 0; i < 23; i++) q.push_back(8'((i * 37 + 5) & 255));
        run_seq(-1);
        wait_bus_quiet();
        chk(words_seen == exp_total, "R3 word count long sequence", words_seen, exp_total);

        // R4 empty sequence
        q.delete();
        run_seq(-1);
        chk(seq_ready == 1'b1, "R4 no quiet period after empty", seq_ready, 1);
        repeat (50) @(negedge clk);
        chk(words_seen == exp_total, "R4 no words for empty", words_seen, exp_total);
        chk(spi_csn == 1'b1, "R4 bus idle for empty", spi_csn, 1);

        // R6 fault on second word of five
        q = '{8'hB0, 8'h01, 8'h02, 8'h03, 8'h04};
        run_seq(1);
        wait_bus_quiet();
        repeat (20) @(negedge clk);
        chk(err_flag == 1'b1, "R6 error set by fault", err_flag, 1);
        chk(words_seen == exp_total, "R6 remaining bytes not sent", words_seen, exp_total);

        // R5 skipped while error
        q = '{8'hAA, 8'hBB, 8'hCC};
        run_seq(-1);
        repeat (300) @(negedge clk);
        chk(words_seen == exp_total, "R5 skipped sequence silent", words_seen, exp_total);
        chk(err_flag == 1'b1, "R5 error still set", err_flag, 1);

        // R8 clear returns previous value
        pulse_clear();
        chk(err_snap == 1'b1, "R8 snapshot of set flag", err_snap, 1);
        chk(err_flag == 1'b0, "R8 flag cleared", err_flag, 0);
        model_err = 1'b0;
        pulse_clear();
        chk(err_snap == 1'b0, "R8 snapshot of clear flag", err_snap, 0);

        // R5 recovery after clear
        q = '{8'h29, 8'h01};
        run_seq(-1);

        // R6 fault on last word
        q = '{8'h10, 8'h20};
        run_seq(1);
        wait_bus_quiet();
        chk(err_flag == 1'b1, "R6 fault on last word", err_flag, 1);
        chk(seq_ready == 1'b0, "R7 quiet period after failed sequence", seq_ready, 0);
        pulse_clear();
        model_err = 1'b0;

        // R6 fault on first word
        q = '{8'hC1, 8'hC2, 8'hC3};
        run_seq(0);
        wait_bus_quiet();
        repeat (20) @(negedge clk);
        chk(words_seen == exp_total, "R6 only first word sent", words_seen, exp_total);
        pulse_clear();
        model_err = 1'b0;

        // R7 command after failed sequence waits the quiet period
        q = '{8'h11};
        run_seq(-1);
        wait_bus_quiet();
        chk(words_seen == exp_total, "R2 final word count", words_seen, exp_total);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        done_flag = 1;
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            fails++;
            vectors++;
            $display("FAIL watchdog actual=%0h expected=%0h", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule